// File: doc/BRIEF.md
# Dual-Mode Display Serial Receiver

This block is the write-only serial front end of a display driver. A host microcontroller sends it command and data bytes over a serial link. The link runs in one of two framings, chosen by a static bus-select input. In the four-wire framing a dedicated command/data pin tags each 8-bit byte. In the three-wire framing that pin is unused, and each 9-bit frame carries the tag as its leading bit. All serial inputs are brought into the system clock through synchronizer chains. Serial-clock rising edges are then detected in the system domain.

Each finished byte leaves the block on an 8-bit bus, together with a command/data flag and a one-cycle valid strobe. A small busy tracker tells the host when it must not send anything. An operation-start pulse raises busy and an operation-done pulse lowers it. A byte that completes while busy is high is thrown away, and a sticky overrun flag records the loss.

The frame engine has three states. FR_IDLE is entered on reset or whenever chip-select is high. FR_FLAG waits for the tag bit of a three-wire frame. FR_BITS shifts the eight byte bits. Its transitions:
- FR_IDLE→FR_FLAG, on chip-select low in three-wire mode.
- FR_IDLE→FR_BITS, on chip-select low in four-wire mode.
- FR_FLAG→FR_BITS, on the tag edge.
- FR_BITS→FR_FLAG or FR_BITS, on the eighth bit edge, by mode.
- Any state→FR_IDLE, on chip-select high.

The busy tracker has two states, BZ_READY and BZ_BUSY:
- BZ_READY→BZ_BUSY, on op_start.
- BZ_BUSY→BZ_READY, on op_done without op_start.

Top module: `dcspi_rx`

## Requirements
- R1: While rst_n is low and after it is released, rx_valid, busy and overrun are 0. A partial frame is discarded by reset.
- R2: With bus_sel=0 (four-wire), eight bits are taken on successive sclk rising edges, most significant first. rx_is_data equals the level of dc_sel during the byte: 0 marks a command, 1 marks data.
- R3: With bus_sel=1 (three-wire), each frame is nine bits. The first bit is the flag (0 = command, 1 = data), followed by the byte most significant first. dc_sel has no effect.
- R4: rx_valid is high for exactly one clk cycle for each accepted byte, and rx_byte/rx_is_data are valid in that cycle.
- R5: sclk edges while cs_n is high are ignored. Raising cs_n in the middle of a frame discards the partial bits, and the next frame starts from its first bit.
- R6: Several frames may follow one another within a single cs_n-low window, and each is delivered in order.
- R7: op_start sets busy from the next cycle. op_done clears busy from the next cycle. When both are high in the same cycle, op_start wins.
- R8: A byte that completes while busy is high produces no rx_valid and sets overrun. Overrun then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Framing select: 0 four-wire, 1 three-wire (static) |
| sclk | input | 1 | Serial clock from host |
| mosi | input | 1 | Serial data from host |
| cs_n | input | 1 | Active-low chip select |
| dc_sel | input | 1 | Command/data pin (four-wire only) |
| op_start | input | 1 | Internal operation begins (raises busy) |
| op_done | input | 1 | Internal operation finished (clears busy) |
| rx_byte | output | 8 | Received byte |
| rx_is_data | output | 1 | 1 = data byte, 0 = command byte |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| busy | output | 1 | Host must not send while high |
| overrun | output | 1 | Sticky: a byte was dropped while busy |

## Verification
The bench builds the block with its default parameters: DATA_W=8 and SYNC_STAGES=2. With these values every byte pattern and both framings can be driven at a serial half-period of four system clocks. Under that condition each serial edge is seen exactly once, and back-to-back frames and aborted frames can be observed cycle by cycle. The two-stage chain keeps the delay from a serial edge to rx_valid short enough that busy-window drops and the op_start/op_done collision can be placed deterministically around a frame.

// File: rtl/dcspi_pkg.sv
package dcspi_pkg;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_FLAG = 2'd1,
        FR_BITS = 2'd2
    } frame_st_t;

    typedef enum logic {
        BZ_READY = 1'b0,
        BZ_BUSY  = 1'b1
    } busy_st_t;

endpackage

// File: rtl/dcspi_sync.sv
module dcspi_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= RST_VAL;
            end
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/dcspi_frame.sv
module dcspi_frame
    import dcspi_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              three_wire,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic              cs_n_s,
    input  logic              dc_s,
    output logic              frm_valid,
    output logic [DATA_W-1:0] frm_data,
    output logic              frm_is_data
);

    localparam int              CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(DATA_W - 1);

    frame_st_t          state_q, state_d;
    logic               sclk_prev_q;
    logic               rise;
    logic [CNT_W-1:0]   cnt_q;
    logic [DATA_W-1:0]  shift_q;
    logic               flag_q;
    logic               valid_q;
    logic               is_data_q;
    logic               last_edge;

    assign rise      = sclk_s & ~sclk_prev_q;
    assign last_edge = (state_q == FR_BITS) && rise && !cs_n_s && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev_q <= 1'b0;
        end else begin
            sclk_prev_q <= sclk_s;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FR_IDLE: begin
                if (!cs_n_s) begin
                    state_d = three_wire ? FR_FLAG : FR_BITS;
                end
            end
            FR_FLAG: begin
                if (cs_n_s) begin
                    state_d = FR_IDLE;
                end else if (rise) begin
                    state_d = FR_BITS;
                end
            end
            FR_BITS: begin
                if (cs_n_s) begin
                    state_d = FR_IDLE;
                end else if (rise && (cnt_q == LAST)) begin
                    state_d = three_wire ? FR_FLAG : FR_BITS;
                end
            end
            default: state_d = FR_IDLE;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            shift_q   <= '0;
            flag_q    <= 1'b0;
            valid_q   <= 1'b0;
            is_data_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (cs_n_s || (state_q == FR_IDLE)) begin
                cnt_q <= '0;
            end else if (rise) begin
                unique case (state_q)
                    FR_FLAG: begin
                        flag_q <= mosi_s;
                    end
                    FR_BITS: begin
                        shift_q <= {shift_q[DATA_W-2:0], mosi_s};
                        if (cnt_q == LAST) begin
                            cnt_q     <= '0;
                            valid_q   <= 1'b1;
                            is_data_q <= three_wire ? flag_q : dc_s;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign frm_valid   = valid_q;
    assign frm_data    = shift_q;
    assign frm_is_data = is_data_q;

    // R5: deselect always returns the engine to idle
    p_idle_on_deselect_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (state_q == FR_IDLE));

    // R3: after a byte in three-wire mode the next bit taken is a flag
    p_flag_follows_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (last_edge && three_wire) |=> (state_q == FR_FLAG));

    // R2: a completed byte raises the frame strobe on the next cycle
    p_byte_completes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        last_edge |=> frm_valid);

endmodule

// File: rtl/dcspi_gate.sv
module dcspi_gate
    import dcspi_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid,
    input  logic [DATA_W-1:0] frm_data,
    input  logic              frm_is_data,
    input  logic              op_start,
    input  logic              op_done,
    output logic              byte_valid,
    output logic [DATA_W-1:0] byte_data,
    output logic              byte_is_data,
    output logic              busy,
    output logic              overrun
);

    busy_st_t           state_q, state_d;
    logic               valid_q;
    logic [DATA_W-1:0]  data_q;
    logic               is_data_q;
    logic               overrun_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BZ_READY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: start has priority over done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BZ_READY: if (op_start) state_d = BZ_BUSY;
            BZ_BUSY:  if (op_done && !op_start) state_d = BZ_READY;
            default:  state_d = BZ_READY;
        endcase
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q   <= 1'b0;
            data_q    <= '0;
            is_data_q <= 1'b0;
            overrun_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (frm_valid) begin
                if (state_q == BZ_READY) begin
                    valid_q   <= 1'b1;
                    data_q    <= frm_data;
                    is_data_q <= frm_is_data;
                end else begin
                    overrun_q <= 1'b1;
                end
            end
        end
    end

    assign byte_valid   = valid_q;
    assign byte_data    = data_q;
    assign byte_is_data = is_data_q;
    assign busy         = (state_q == BZ_BUSY);
    assign overrun      = overrun_q;

    // R4: strobe never lasts more than one cycle
    p_single_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

    // R7: start raises busy, lone done clears it
    p_busy_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> busy);
    p_busy_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !op_start) |=> !busy);

    // R8: a byte arriving while busy is dropped and flagged
    p_drop_when_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && busy) |=> (overrun && !byte_valid));
    p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

endmodule

// File: rtl/dcspi_rx.sv
module dcspi_rx
    import dcspi_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              sclk,
    input  logic              mosi,
    input  logic              cs_n,
    input  logic              dc_sel,
    input  logic              op_start,
    input  logic              op_done,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_is_data,
    output logic              rx_valid,
    output logic              busy,
    output logic              overrun
);

    localparam int NSYNC = 5;
    // bit order: {bus_sel, dc_sel, cs_n, mosi, sclk}; cs_n resets high
    localparam logic [NSYNC-1:0] SYNC_RST = 5'b00100;

    logic [NSYNC-1:0]  raw_in, sync_out;
    logic              frm_valid;
    logic [DATA_W-1:0] frm_data;
    logic              frm_is_data;

    assign raw_in = {bus_sel, dc_sel, cs_n, mosi, sclk};

    dcspi_sync #(
        .W       (NSYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_out)
    );

    dcspi_frame #(
        .DATA_W (DATA_W)
    ) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .three_wire  (sync_out[4]),
        .sclk_s      (sync_out[0]),
        .mosi_s      (sync_out[1]),
        .cs_n_s      (sync_out[2]),
        .dc_s        (sync_out[3]),
        .frm_valid   (frm_valid),
        .frm_data    (frm_data),
        .frm_is_data (frm_is_data)
    );

    dcspi_gate #(
        .DATA_W (DATA_W)
    ) u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .frm_valid    (frm_valid),
        .frm_data     (frm_data),
        .frm_is_data  (frm_is_data),
        .op_start     (op_start),
        .op_done      (op_done),
        .byte_valid   (rx_valid),
        .byte_data    (rx_byte),
        .byte_is_data (rx_is_data),
        .busy         (busy),
        .overrun      (overrun)
    );

    // R1: nothing is flagged in the cycle after reset is released
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!rx_valid && !busy && !overrun));

endmodule

// File: tb/dcspi_rx_bench.sv
`timescale 1ns/1ps
module dcspi_rx_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       sclk = 1'b0;
    logic       mosi = 1'b0;
    logic       cs_n = 1'b1;
    logic       dc_sel = 1'b0;
    logic       op_start = 1'b0;
    logic       op_done = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_is_data;
    logic       rx_valid;
    logic       busy;
    logic       overrun;

    int n_checks = 0;
    int n_fail = 0;
    int log_n = 0;
    int double_cnt = 0;
    logic [7:0] log_b [0:63];
    logic       log_d [0:63];
    logic       prev_valid = 1'b0;

    always #2.5 clk = ~clk;

    dcspi_rx u_dcspi_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .sclk       (sclk),
        .mosi       (mosi),
        .cs_n       (cs_n),
        .dc_sel     (dc_sel),
        .op_start   (op_start),
        .op_done    (op_done),
        .rx_byte    (rx_byte),
        .rx_is_data (rx_is_data),
        .rx_valid   (rx_valid),
        .busy       (busy),
        .overrun    (overrun)
    );

    // Monitor, sampling at the falling clock edge
    always @(negedge clk) begin
        if (rx_valid) begin
            if (log_n < 64) begin
                log_b[log_n] = rx_byte;
                log_d[log_n] = rx_is_data;
            end
            log_n = log_n + 1;
        end
        if (rx_valid && prev_valid) double_cnt = double_cnt + 1;
        prev_valid = rx_valid;
    end

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [8:0] bits, input int nbits);
        for (int i = nbits - 1; i >= 0; i--) begin
            sclk = 1'b0;
            mosi = bits[i];
            wait_clks(4);
            sclk = 1'b1;
            wait_clks(4);
        end
        sclk = 1'b0;
    endtask

    task automatic select_on();
        cs_n = 1'b0;
        wait_clks(6);
    endtask

    task automatic select_off();
        wait_clks(4);
        cs_n = 1'b1;
        wait_clks(10);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wait_clks(3);
        check_eq("R1", "rx_valid in reset", int'(rx_valid), 0);
        check_eq("R1", "busy in reset", int'(busy), 0);
        check_eq("R1", "overrun in reset", int'(overrun), 0);
        rst_n = 1'b1;
        wait_clks(4);
    endtask

    task automatic t_four_wire();
        int base = log_n;
        bus_sel = 1'b0;
        wait_clks(4);
        select_on();
        dc_sel = 1'b0; send_bits({1'b0, 8'hA5}, 8);
        dc_sel = 1'b1; send_bits({1'b0, 8'h3C}, 8);
        dc_sel = 1'b1; send_bits({1'b0, 8'h01}, 8);
        select_off();
        check_eq("R6", "four-wire byte count", log_n - base, 3);
        check_eq("R2", "byte0 value", int'(log_b[base]), 'hA5);
        check_eq("R2", "byte0 command flag", int'(log_d[base]), 0);
        check_eq("R2", "byte1 value", int'(log_b[base+1]), 'h3C);
        check_eq("R2", "byte1 data flag", int'(log_d[base+1]), 1);
        check_eq("R6", "byte2 value", int'(log_b[base+2]), 'h01);
    endtask

    task automatic t_three_wire();
        int base = log_n;
        bus_sel = 1'b1;
        dc_sel = 1'b1;
        wait_clks(4);
        select_on();
        send_bits({1'b0, 8'h12}, 9);
        dc_sel = 1'b0;
        send_bits({1'b1, 8'hF0}, 9);
        send_bits({1'b1, 8'h80}, 9);
        select_off();
        check_eq("R3", "three-wire byte count", log_n - base, 3);
        check_eq("R3", "frame0 value", int'(log_b[base]), 'h12);
        check_eq("R3", "frame0 command despite dc_sel high", int'(log_d[base]), 0);
        check_eq("R3", "frame1 value", int'(log_b[base+1]), 'hF0);
        check_eq("R3", "frame1 data despite dc_sel low", int'(log_d[base+1]), 1);
        check_eq("R3", "frame2 value", int'(log_b[base+2]), 'h80);
        bus_sel = 1'b0;
        wait_clks(4);
    endtask

    task automatic t_abort();
        int base = log_n;
        bus_sel = 1'b0;
        dc_sel = 1'b1;
        wait_clks(4);
        select_on();
        send_bits({1'b0, 8'hF0}, 4);
        select_off();
        send_bits({1'b0, 8'hFF}, 8);
        wait_clks(10);
        check_eq("R5", "no byte from aborted or deselected bits", log_n - base, 0);
        select_on();
        send_bits({1'b0, 8'h81}, 8);
        select_off();
        check_eq("R5", "count after fresh frame", log_n - base, 1);
        check_eq("R5", "fresh frame value", int'(log_b[base]), 'h81);
    endtask

    task automatic t_strobe();
        check_eq("R4", "strobes longer than one cycle", double_cnt, 0);
    endtask

    task automatic t_busy();
        int base;
        op_start = 1'b1;
        wait_clks(1);
        op_start = 1'b0;
        check_eq("R7", "busy after op_start", int'(busy), 1);
        base = log_n;
        bus_sel = 1'b0;
        dc_sel = 1'b0;
        select_on();
        send_bits({1'b0, 8'h55}, 8);
        select_off();
        check_eq("R8", "no strobe while busy", log_n - base, 0);
        check_eq("R8", "overrun set", int'(overrun), 1);
        op_start = 1'b1;
        op_done = 1'b1;
        wait_clks(1);
        op_start = 1'b0;
        op_done = 1'b0;
        check_eq("R7", "start beats done", int'(busy), 1);
        op_done = 1'b1;
        wait_clks(1);
        op_done = 1'b0;
        check_eq("R7", "busy cleared by op_done", int'(busy), 0);
        check_eq("R8", "overrun sticky", int'(overrun), 1);
        base = log_n;
        select_on();
        send_bits({1'b0, 8'hC3}, 8);
        select_off();
        check_eq("R8", "byte accepted after done", log_n - base, 1);
        check_eq("R8", "accepted value", int'(log_b[base]), 'hC3);
        check_eq("R8", "overrun still set", int'(overrun), 1);
    endtask

    task automatic t_reset_mid_frame();
        int base = log_n;
        bus_sel = 1'b0;
        select_on();
        send_bits({1'b0, 8'hE0}, 4);
        do_reset();
        send_bits({1'b0, 8'h0F}, 4);
        select_off();
        check_eq("R1", "partial frame lost on reset", log_n - base, 0);
        check_eq("R1", "overrun cleared by reset", int'(overrun), 0);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        wait_clks(2);
        do_reset();
        t_four_wire();
        t_three_wire();
        t_abort();
        t_busy();
        t_reset_mid_frame();
        t_strobe();
        finish_run();
    end

endmodule